// File: doc/BRIEF.md
# Confidence-Based Fetch Gating Controller

This block sits next to the fetch stage of a speculative processor and decides, every cycle, whether fetch may go on. A branch confidence estimator tags each fetched branch as high or low confidence. The block keeps a running count of low-confidence branches that have been fetched but not yet resolved.

When that count rises above a software-programmed threshold, the block raises a registered fetch-stall signal. This keeps instructions that are probably on a wrong path out of decode, issue and execute. When the branches resolve, or a flush squashes them, the count falls and fetch resumes.

The threshold lives in a register inside the block. A write to it takes effect only while fetch is not stalled, so the limit cannot change under an active stall.

Top module: `fetch_gate`

## Requirements
- R1: A fetch or resolve event whose low-confidence flag is 0, or whose valid is 0, leaves the count unchanged.
- R2: A low-confidence fetch (brFetchVld=1, brFetchLowConf=1) with no low-confidence resolve and no flush raises the count by one on the next clock edge.
- R3: A low-confidence resolve (brResolveVld=1, brResolveLowConf=1) with no low-confidence fetch and no flush lowers the count by one on the next clock edge.
- R4: A low-confidence fetch and a low-confidence resolve in the same cycle, with no flush, leave the count unchanged.
- R5: flush=1 sets the count to zero on the next edge, whatever else is asserted in that cycle.
- R6: The count saturates at 2^CNT_W-1 (15 by default) and holds at 0 rather than wrapping below it.
- R7: stallFetch is registered. It is 1 in the cycle after the count is strictly greater than the threshold, and 0 in the cycle after the count is less than or equal to the threshold.
- R8: With thrWrEn=1, thrWrData is loaded into the threshold only while stallFetch is 0. A write while stallFetch is 1 is ignored.
- R9: After reset the count is 0, stallFetch is 0 and the threshold is THR_RST (3 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brFetchVld | input | 1 | A branch was fetched this cycle |
| brFetchLowConf | input | 1 | The fetched branch is low confidence |
| brResolveVld | input | 1 | A branch resolved this cycle |
| brResolveLowConf | input | 1 | The resolving branch had been fetched as low confidence |
| flush | input | 1 | Pipeline flush; squashes all in-flight branches |
| thrWrEn | input | 1 | Threshold write request |
| thrWrData | input | CNT_W | Threshold value to write |
| stallFetch | output | 1 | Fetch must stall this cycle |
| lowConfCount | output | CNT_W | Current count of unresolved low-confidence branches |

## Verification
The hardest state to reach from the ports is a threshold write arriving while the stall is up. The bench can only judge whether that write was dropped from the stall behaviour that follows.

To reach it, the bench programs each threshold from 0 to 15 in turn and ramps the count up past that threshold and on into saturation. While stalled, it attempts a conflicting write. It then drains the count to zero, checking that the stall falls exactly one cycle after the count reaches the original threshold.

Simultaneous fetch and resolve at saturation and at zero are covered on the same ramps. A long mixed stream with occasional flushes follows.

// File: rtl/fetch_gate_pkg.sv
package fetch_gate_pkg;
  // Strobes from control to datapath, one cycle's worth of intent
  typedef struct packed {
    logic clr;    // flush: count to zero
    logic inc;    // net increment
    logic dec;    // net decrement
    logic ldThr;  // accepted threshold write
  } gateStrb_t;
endpackage

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl
  import fetch_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      brFetchVld,
  input  logic      brFetchLowConf,
  input  logic      brResolveVld,
  input  logic      brResolveLowConf,
  input  logic      flush,
  input  logic      thrWrEn,
  input  logic      overThr,
  output gateStrb_t strb,
  output logic      stallQ
);
  logic lowFetch;
  logic lowResolve;

  assign lowFetch   = brFetchVld & brFetchLowConf;
  assign lowResolve = brResolveVld & brResolveLowConf;

  always_comb begin
    strb       = '0;
    strb.clr   = flush;
    strb.inc   = lowFetch & ~lowResolve & ~flush;
    strb.dec   = lowResolve & ~lowFetch & ~flush;
    strb.ldThr = thrWrEn & ~stallQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stallQ <= 1'b0;
    else       stallQ <= overThr;
  end

  // R7
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    overThr |=> stallQ);
  // R7
  stall_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !overThr |=> !stallQ);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.inc && strb.dec));
endmodule

// File: rtl/fetch_gate_dp.sv
module fetch_gate_dp
  import fetch_gate_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int THR_RST = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrb_t        strb,
  input  logic [CNT_W-1:0] thrWrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] thrQ,
  output logic             overThr
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic atMax;
  logic atZero;

  assign atMax  = (cntQ == CntMax);
  assign atZero = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                     cntQ <= '0;
    else if (strb.clr)             cntQ <= '0;
    else if (strb.inc && !atMax)   cntQ <= cntQ + CntOne;
    else if (strb.dec && !atZero)  cntQ <= cntQ - CntOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           thrQ <= CNT_W'(THR_RST);
    else if (strb.ldThr) thrQ <= thrWrData;
  end

  assign overThr = (cntQ > thrQ);

  // R5
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cntQ == '0));
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !atMax) |=> (cntQ == $past(cntQ) + CntOne));
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !atZero) |=> (cntQ == $past(cntQ) - CntOne));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && !strb.clr && !strb.dec) |=> (cntQ == CntMax));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atZero && !strb.inc) |=> (cntQ == '0));
endmodule

// File: rtl/fetch_gate.sv
module fetch_gate
  import fetch_gate_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int THR_RST = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brFetchVld,
  input  logic             brFetchLowConf,
  input  logic             brResolveVld,
  input  logic             brResolveLowConf,
  input  logic             flush,
  input  logic             thrWrEn,
  input  logic [CNT_W-1:0] thrWrData,
  output logic             stallFetch,
  output logic [CNT_W-1:0] lowConfCount
);
  gateStrb_t        strb;
  logic             overThr;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] thrQ;

  fetch_gate_ctrl ctrl_i (
    .clk              (clk),
    .rstN             (rstN),
    .brFetchVld       (brFetchVld),
    .brFetchLowConf   (brFetchLowConf),
    .brResolveVld     (brResolveVld),
    .brResolveLowConf (brResolveLowConf),
    .flush            (flush),
    .thrWrEn          (thrWrEn),
    .overThr          (overThr),
    .strb             (strb),
    .stallQ           (stallFetch)
  );

  fetch_gate_dp #(.CNT_W(CNT_W), .THR_RST(THR_RST)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .thrWrData (thrWrData),
    .cntQ      (cntQ),
    .thrQ      (thrQ),
    .overThr   (overThr)
  );

  assign lowConfCount = cntQ;

  // R1
  ignore_high_conf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !(brFetchVld && brFetchLowConf) && !(brResolveVld && brResolveLowConf))
      |=> $stable(lowConfCount));
  // R4
  balanced_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && brFetchVld && brFetchLowConf && brResolveVld && brResolveLowConf)
      |=> $stable(lowConfCount));
  // R8
  thr_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallFetch |=> $stable(thrQ));
endmodule

// File: tb/fetch_gate_tb_top.sv
module fetch_gate_tb_top;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;
  localparam int THR0 = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, fV, fL, rV, rL, fls, we;
  logic [W-1:0] wd;
  logic stallFetch;
  logic [W-1:0] lowConfCount;

  int checks = 0;
  int fails  = 0;
  int expCnt, expThr;
  bit expStall;

  fetch_gate #(.CNT_W(W), .THR_RST(THR0)) dut_i (
    .clk(clk), .rstN(rstN), .brFetchVld(fV), .brFetchLowConf(fL),
    .brResolveVld(rV), .brResolveLowConf(rL), .flush(fls),
    .thrWrEn(we), .thrWrData(wd),
    .stallFetch(stallFetch), .lowConfCount(lowConfCount));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock of stimulus; model is updated from the requirements.
  task automatic step(bit a, bit b, bit c, bit d, bit e, bit w, int v, string req);
    bit newStall;
    bit lf, lr;
    @(negedge clk);
    fV = a; fL = b; rV = c; rL = d; fls = e; we = w; wd = W'(v);
    @(posedge clk);
    newStall = (expCnt > expThr);           // R7: registered compare
    if (w && !expStall) expThr = v;         // R8
    lf = a && b;
    lr = c && d;
    if (e)                 expCnt = 0;                          // R5
    else if (lf && !lr)    expCnt = (expCnt < MAXV) ? expCnt + 1 : MAXV;  // R2 R6
    else if (lr && !lf)    expCnt = (expCnt > 0) ? expCnt - 1 : 0;         // R3 R6
    expStall = newStall;
    #2;
    check({req, " count"}, int'(lowConfCount), expCnt);
    check({req, " stall"}, int'(stallFetch), int'(expStall));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; fV = 0; fL = 0; rV = 0; rL = 0; fls = 0; we = 0; wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expCnt = 0; expThr = THR0; expStall = 1'b0;
    #1;
    check("R9 reset count", int'(lowConfCount), 0);
    check("R9 reset stall", int'(stallFetch), 0);

    // R9: default threshold observed via stall onset
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, "R7");

    for (int t = 0; t <= MAXV; t++) begin
      step(1, 1, 0, 0, 1, 0, 0, "R5");        // flush beats fetch
      step(0, 0, 0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, 1, t, "R8");        // accepted write
      for (int i = 0; i < MAXV + 2; i++) begin
        step(1, 1, 0, 0, 0, 0, 0, "R2");
        if (expStall) step(0, 0, 0, 0, 0, 1, (t + 5) % (MAXV + 1), "R8");
      end
      step(1, 1, 1, 1, 0, 0, 0, "R4");        // at saturation
      step(1, 0, 1, 0, 0, 0, 0, "R1");
      step(0, 1, 0, 1, 0, 0, 0, "R1");
      step(1, 1, 0, 0, 0, 0, 0, "R6");
      for (int i = 0; i < MAXV + 2; i++) step(0, 0, 1, 1, 0, 0, 0, "R3");
      step(1, 1, 1, 1, 0, 0, 0, "R4");        // at zero
      step(0, 0, 1, 1, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 0, 0, 0, "R7");
    end

    for (int i = 0; i < 4000; i++) begin
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           (($urandom % 40) == 0), (($urandom % 8) == 0), int'($urandom % (MAXV + 1)),
           "mixed");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule